// File: doc/BRIEF.md
# Constrained Flag-Combination Sequencer

This block produces, one at a time and in a fixed order, every legal setting of a vector of single-bit test flags. A test harness uses it to sweep a large space of configurations. The space covers permission bits of two levels of translation entry, the kind of access performed and several processor control bits. Settings that break a fixed set of combination rules are skipped without ever being shown. The vector advances as a ripple increment that starts at flag 0: set flags are cleared until the first clear flag is found, and that flag is set. When the vector would wrap past all ones, the sweep is over.

A `start` pulse opens a sweep with the all-zeros vector, which is always legal. The consumer then holds `step_req` high until it sees a one-cycle `step_ack`. Between those two points the controller runs at most one increment and one legality test per clock. It keeps incrementing until the result is legal or the vector wraps. The controller has four states. IDLE waits for start. SHOW presents a legal vector with `flags_valid` high. SEEK runs the increments. FINISH holds the zero vector with `seq_done` high.

The transitions are: any state to SHOW on start; SHOW to SEEK on a step request; SEEK to SHOW on a legal increment; SEEK to FINISH on wrap; SEEK to SEEK on an illegal increment. Reset returns the block to IDLE. A counter reports how many legal vectors the current sweep has shown.

Top module: `flagset_sequencer`

## Requirements
- R1: A synchronous reset puts the block in IDLE, with `flags` zero, `flags_valid`, `seq_done` and `step_ack` low, and `legal_count` zero.
- R2: One clock edge after `start` is sampled high, `flags` is all zeros, `flags_valid` is high and `legal_count` is 1.
- R3: Each step presents the next legal vector in ascending binary order of `flags` read as an unsigned number with flag 0 as the least significant bit. That order is the one produced by the ripple increment from flag 0 upward.
- R4: No vector with both the fetch-access flag (index `FETCH_IDX`) and the write-access flag (index `WRITE_IDX`) set is ever presented as valid.
- R5: No vector with both the user-access flag (`USER_IDX`) and the execution-guard enable flag (`XGUARD_IDX`) set is ever presented as valid.
- R6: No vector with the key access-deny flag (`KEY_AD_IDX`) or the key write-deny flag (`KEY_WD_IDX`) set while the key-enable flag (`KEY_EN_IDX`) is clear is ever presented as valid.
- R7: No vector with the large-page reserved-bit flag (`BIG_RSV_IDX`) set while the large-page flag (`BIG_PG_IDX`) is clear is ever presented as valid.
- R8: One increment is evaluated per clock. `step_ack` rises k+1 cycles after `step_req` is first sampled, where k is the number of increments needed to reach the next legal vector or the wrap.
- R9: A step from the last legal vector sets `flags` to zero, drops `flags_valid`, raises `seq_done` and acknowledges. `legal_count` then equals the number of legal vectors.
- R10: `legal_count` rises by exactly one for every legal vector presented after the first.
- R11: `start` takes priority over everything else in the same cycle. In any state, including SEEK and SHOW with a step pending, it restarts the sweep as in R2 and gives no acknowledge.
- R12: `step_req` has no effect in IDLE or FINISH: `flags`, `seq_done`, `flags_valid` and `legal_count` hold and no acknowledge occurs.
- R13: `step_ack` is a one-cycle pulse and is high only while `flags_valid` or `seq_done` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin (or restart) a sweep at the all-zeros vector |
| step_req | input | 1 | Request the next legal vector; hold until acknowledged |
| step_ack | output | 1 | One-cycle acknowledge of a step |
| flags | output | NUM_FLAGS | Current flag vector |
| flags_valid | output | 1 | High while a legal vector is presented |
| seq_done | output | 1 | High once the vector has wrapped |
| legal_count | output | CNT_W | Legal vectors presented in this sweep |

## Verification
Two events can land in the same cycle. The first is a restart and an increment: `start` is raised together with `step_req` in SHOW, and also in the middle of a SEEK run. In both cases the bench expects the zero vector, a count of 1 and no acknowledge. The second is the wrap and the acknowledge, which fall together on the final step; there the bench expects `seq_done`, a zero vector and the full legal total on the same edge as `step_ack`. A bench model walks the same increment and rules to predict every vector and every acknowledge latency, while random gaps and random restart points vary the timing.

// File: rtl/flag_seq_pkg.sv
package flag_seq_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE   = 2'd0,
        SQ_SHOW   = 2'd1,
        SQ_SEEK   = 2'd2,
        SQ_FINISH = 2'd3
    } seq_state_e;

endpackage

// File: rtl/flag_ripple_inc.sv
module flag_ripple_inc #(
    parameter int W = 27
) (
    input  logic [W-1:0] cur,
    output logic [W-1:0] nxt,
    output logic         wrap
);
    // carry[i] is high while every flag below i was set (and gets cleared)
    logic [W:0] carry;

    assign carry[0] = 1'b1;

    for (genvar i = 0; i < W; i++) begin : g_stage
        assign nxt[i]     = cur[i] ^ carry[i];
        assign carry[i+1] = carry[i] & cur[i];
    end

    assign wrap = carry[W];

endmodule

// File: rtl/flag_legal_filter.sv
module flag_legal_filter #(
    parameter int W           = 27,
    parameter int WRITE_IDX   = 20,
    parameter int FETCH_IDX   = 21,
    parameter int USER_IDX    = 19,
    parameter int XGUARD_IDX  = 25,
    parameter int KEY_AD_IDX  = 16,
    parameter int KEY_WD_IDX  = 17,
    parameter int KEY_EN_IDX  = 26,
    parameter int BIG_RSV_IDX = 15,
    parameter int BIG_PG_IDX  = 12
) (
    input  logic [W-1:0] vec,
    output logic         legal
);
    logic clash_fetch_write;
    logic clash_user_guard;
    logic orphan_key;
    logic orphan_rsv;

    always_comb begin
        clash_fetch_write = vec[FETCH_IDX] & vec[WRITE_IDX];
        clash_user_guard  = vec[USER_IDX] & vec[XGUARD_IDX];
        orphan_key        = (vec[KEY_AD_IDX] | vec[KEY_WD_IDX]) & ~vec[KEY_EN_IDX];
        orphan_rsv        = vec[BIG_RSV_IDX] & ~vec[BIG_PG_IDX];
        legal = ~(clash_fetch_write | clash_user_guard | orphan_key | orphan_rsv);
    end

endmodule

// File: rtl/flag_legal_counter.sv
module flag_legal_counter #(
    parameter int CNT_W = 28
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_one,
    input  logic             bump,
    output logic [CNT_W-1:0] count
);
    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else if (load_one) begin
            count_q <= CNT_W'(1);
        end else if (bump) begin
            count_q <= count_q + CNT_W'(1);
        end
    end

    assign count = count_q;

endmodule

// File: rtl/flagset_sequencer.sv
module flagset_sequencer
    import flag_seq_pkg::*;
#(
    parameter int NUM_FLAGS   = 27,
    parameter int CNT_W       = NUM_FLAGS + 1,
    parameter int WRITE_IDX   = 20,
    parameter int FETCH_IDX   = 21,
    parameter int USER_IDX    = 19,
    parameter int XGUARD_IDX  = 25,
    parameter int KEY_AD_IDX  = 16,
    parameter int KEY_WD_IDX  = 17,
    parameter int KEY_EN_IDX  = 26,
    parameter int BIG_RSV_IDX = 15,
    parameter int BIG_PG_IDX  = 12
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic                 step_req,
    output logic                 step_ack,
    output logic [NUM_FLAGS-1:0] flags,
    output logic                 flags_valid,
    output logic                 seq_done,
    output logic [CNT_W-1:0]     legal_count
);
    seq_state_e           state_q, state_d;
    logic [NUM_FLAGS-1:0] flags_q;
    logic [NUM_FLAGS-1:0] inc_vec;
    logic                 inc_wrap;
    logic                 inc_legal;
    logic                 ack_q;
    logic                 seek_hit;

    flag_ripple_inc #(.W(NUM_FLAGS)) u_inc (
        .cur  (flags_q),
        .nxt  (inc_vec),
        .wrap (inc_wrap)
    );

    flag_legal_filter #(
        .W           (NUM_FLAGS),
        .WRITE_IDX   (WRITE_IDX),
        .FETCH_IDX   (FETCH_IDX),
        .USER_IDX    (USER_IDX),
        .XGUARD_IDX  (XGUARD_IDX),
        .KEY_AD_IDX  (KEY_AD_IDX),
        .KEY_WD_IDX  (KEY_WD_IDX),
        .KEY_EN_IDX  (KEY_EN_IDX),
        .BIG_RSV_IDX (BIG_RSV_IDX),
        .BIG_PG_IDX  (BIG_PG_IDX)
    ) u_filter (
        .vec   (inc_vec),
        .legal (inc_legal)
    );

    // a SEEK cycle that lands on a legal vector without wrapping
    assign seek_hit = (state_q == SQ_SEEK) && !start && !inc_wrap && inc_legal;

    flag_legal_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load_one (start),
        .bump     (seek_hit),
        .count    (legal_count)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (start) begin
            state_d = SQ_SHOW;
        end else begin
            unique case (state_q)
                SQ_IDLE:   state_d = SQ_IDLE;
                SQ_SHOW:   if (step_req) state_d = SQ_SEEK;
                SQ_SEEK: begin
                    if (inc_wrap)       state_d = SQ_FINISH;
                    else if (inc_legal) state_d = SQ_SHOW;
                end
                SQ_FINISH: state_d = SQ_FINISH;
                default:   state_d = SQ_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= SQ_IDLE;
        else     state_q <= state_d;
    end

    // output registers
    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            ack_q   <= 1'b0;
        end else begin
            ack_q <= 1'b0;
            if (start) begin
                flags_q <= '0;
            end else if (state_q == SQ_SEEK) begin
                flags_q <= inc_vec;
                ack_q   <= inc_wrap | inc_legal;
            end
        end
    end

    assign flags       = flags_q;
    assign step_ack    = ack_q;
    assign flags_valid = (state_q == SQ_SHOW);
    assign seq_done    = (state_q == SQ_FINISH);

endmodule

// File: rtl/flag_seq_chk.sv
module flag_seq_chk #(
    parameter int NUM_FLAGS   = 27,
    parameter int CNT_W       = NUM_FLAGS + 1,
    parameter int WRITE_IDX   = 20,
    parameter int FETCH_IDX   = 21,
    parameter int USER_IDX    = 19,
    parameter int XGUARD_IDX  = 25,
    parameter int KEY_AD_IDX  = 16,
    parameter int KEY_WD_IDX  = 17,
    parameter int KEY_EN_IDX  = 26,
    parameter int BIG_RSV_IDX = 15,
    parameter int BIG_PG_IDX  = 12
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 start,
    input logic                 step_ack,
    input logic [NUM_FLAGS-1:0] flags,
    input logic                 flags_valid,
    input logic                 seq_done,
    input logic [CNT_W-1:0]     legal_count
);
    AST_NO_FETCH_WRITE: assert property (@(posedge clk) disable iff (rst)
        flags_valid |-> !(flags[FETCH_IDX] && flags[WRITE_IDX])); // R4

    AST_NO_USER_GUARD: assert property (@(posedge clk) disable iff (rst)
        flags_valid |-> !(flags[USER_IDX] && flags[XGUARD_IDX])); // R5

    AST_KEY_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        (flags_valid && (flags[KEY_AD_IDX] || flags[KEY_WD_IDX])) |-> flags[KEY_EN_IDX]); // R6

    AST_RSV_NEEDS_BIG: assert property (@(posedge clk) disable iff (rst)
        (flags_valid && flags[BIG_RSV_IDX]) |-> flags[BIG_PG_IDX]); // R7

    AST_DONE_ZERO: assert property (@(posedge clk) disable iff (rst)
        seq_done |-> (flags == '0 && !flags_valid)); // R9

    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (rst)
        step_ack |=> !step_ack); // R13

    AST_ACK_WHEN_SHOWN: assert property (@(posedge clk) disable iff (rst)
        step_ack |-> (flags_valid || seq_done)); // R13

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        !$past(start) |-> (legal_count == $past(legal_count) ||
                           legal_count == $past(legal_count) + 1'b1)); // R10

    AST_ASCENDING: assert property (@(posedge clk) disable iff (rst)
        (flags_valid && !$past(flags_valid) && !$past(start)) |-> (flags > $past(flags))); // R3

    AST_RESTART: assert property (@(posedge clk) disable iff (rst)
        start |=> (flags_valid && flags == '0 && !step_ack)); // R11
endmodule

bind flagset_sequencer flag_seq_chk #(
    .NUM_FLAGS   (NUM_FLAGS),
    .CNT_W       (CNT_W),
    .WRITE_IDX   (WRITE_IDX),
    .FETCH_IDX   (FETCH_IDX),
    .USER_IDX    (USER_IDX),
    .XGUARD_IDX  (XGUARD_IDX),
    .KEY_AD_IDX  (KEY_AD_IDX),
    .KEY_WD_IDX  (KEY_WD_IDX),
    .KEY_EN_IDX  (KEY_EN_IDX),
    .BIG_RSV_IDX (BIG_RSV_IDX),
    .BIG_PG_IDX  (BIG_PG_IDX)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .step_ack    (step_ack),
    .flags       (flags),
    .flags_valid (flags_valid),
    .seq_done    (seq_done),
    .legal_count (legal_count)
);

// File: tb/tb_flagset_sequencer.sv
module tb_flagset_sequencer;
    localparam int N    = 10;
    localparam int CW   = N + 1;
    localparam int I_WR = 0, I_FE = 1, I_US = 2, I_XG = 3, I_AD = 4;
    localparam int I_WD = 5, I_EN = 6, I_RS = 7, I_BG = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          step_req = 1'b0;
    logic          step_ack;
    logic [N-1:0]  flags;
    logic          flags_valid;
    logic          seq_done;
    logic [CW-1:0] legal_count;

    int checks = 0;
    int fails  = 0;
    int total_legal;

    always #10 clk = ~clk;

    flagset_sequencer #(
        .NUM_FLAGS(N), .CNT_W(CW),
        .WRITE_IDX(I_WR), .FETCH_IDX(I_FE), .USER_IDX(I_US), .XGUARD_IDX(I_XG),
        .KEY_AD_IDX(I_AD), .KEY_WD_IDX(I_WD), .KEY_EN_IDX(I_EN),
        .BIG_RSV_IDX(I_RS), .BIG_PG_IDX(I_BG)
    ) dut (
        .clk(clk), .rst(rst), .start(start), .step_req(step_req),
        .step_ack(step_ack), .flags(flags), .flags_valid(flags_valid),
        .seq_done(seq_done), .legal_count(legal_count)
    );

    function automatic bit rule_ok(int v);
        bit [N-1:0] b = v[N-1:0];
        if (b[I_FE] && b[I_WR]) return 0;
        if (b[I_US] && b[I_XG]) return 0;
        if ((b[I_AD] || b[I_WD]) && !b[I_EN]) return 0;
        if (b[I_RS] && !b[I_BG]) return 0;
        return 1;
    endfunction

    function automatic int legal_total();
        int t = 0;
        for (int v = 0; v < (1 << N); v++) if (rule_ok(v)) t++;
        return t;
    endfunction

    // returns next legal value after cur (or 1<<N on wrap), increments in k
    function automatic int next_legal(int cur, output int k);
        int v = cur;
        k = 0;
        do begin v++; k++; end while (v < (1 << N) && !rule_ok(v));
        return v;
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; start = 1'b0; step_req = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        chk(flags == 0 && !flags_valid && !seq_done && !step_ack && legal_count == 0,
            "R1", "reset state flags", int'(flags), 0);
    endtask

    task automatic do_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(flags == 0 && flags_valid && legal_count == 1, "R2", "first vector count",
            int'(legal_count), 1);
    endtask

    task automatic step_once(output int waited);
        step_req = 1'b1;
        waited = 0;
        do begin @(negedge clk); waited++; end while (!step_ack && waited < 5000);
        step_req = 1'b0;
    endtask

    task automatic step_ignored(string req);
        logic [N-1:0]  f0 = flags;
        logic [CW-1:0] c0 = legal_count;
        logic          d0 = seq_done;
        step_req = 1'b1;
        repeat (3) begin
            @(negedge clk);
            chk(flags == f0 && legal_count == c0 && seq_done == d0 && !step_ack && !flags_valid,
                req, "step ignored flags", int'(flags), int'(f0));
        end
        step_req = 1'b0;
    endtask

    // full walk from a fresh start; checks every vector, latency and count
    task automatic full_walk(bit rand_gaps);
        int cur = 0, exp_v, k, waited, shown = 1;
        do_start();
        forever begin
            exp_v = next_legal(cur, k);
            step_once(waited);
            chk(waited == k + 1, "R8", "ack latency", waited, k + 1);
            if (exp_v == (1 << N)) begin
                chk(seq_done && !flags_valid && flags == 0, "R9", "wrap done flags",
                    int'(flags), 0);
                chk(legal_count == total_legal, "R9", "final count",
                    int'(legal_count), total_legal);
                break;
            end
            shown++;
            chk(flags_valid && int'(flags) == exp_v, "R3", "next vector", int'(flags), exp_v);
            chk(rule_ok(int'(flags)), "R4", "presented vector obeys rules R5 R6 R7",
                int'(flags), exp_v);
            chk(legal_count == shown, "R10", "count", int'(legal_count), shown);
            @(negedge clk);
            chk(!step_ack && flags_valid && int'(flags) == exp_v, "R13", "ack single pulse",
                int'(step_ack), 0);
            if (rand_gaps) repeat ($urandom_range(0, 3)) @(negedge clk);
            cur = exp_v;
        end
        @(negedge clk);
        chk(!step_ack && seq_done, "R13", "ack single pulse at done", int'(step_ack), 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : main
        int unsigned seed = 32'h5EED_0A17;
        int waited, m;
        void'($urandom(seed));
        total_legal = legal_total();

        do_reset();
        step_ignored("R12");          // step in IDLE

        full_walk(1'b0);
        step_ignored("R12");          // step in FINISH

        // restart from FINISH
        do_start();

        // R11: start and step_req together in SHOW
        repeat (3) step_once(waited);
        start = 1'b1; step_req = 1'b1;
        @(negedge clk);
        start = 1'b0; step_req = 1'b0;
        chk(flags == 0 && flags_valid && legal_count == 1 && !step_ack, "R11",
            "start with step in SHOW", int'(flags), 0);
        @(negedge clk);
        chk(flags == 0 && flags_valid && !step_ack, "R11", "holds after restart",
            int'(flags), 0);

        // R11: start in the middle of a SEEK run (random depth into the sweep)
        for (int t = 0; t < 6; t++) begin
            m = $urandom_range(1, 20);
            repeat (m) step_once(waited);
            step_req = 1'b1;
            @(negedge clk);
            step_req = 1'b0; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            chk(flags == 0 && flags_valid && legal_count == 1 && !step_ack, "R11",
                "start during SEEK", int'(legal_count), 1);
        end

        // second walk with random gaps
        full_walk(1'b1);

        // reset from FINISH
        do_reset();

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule